// File: doc/BRIEF.md
# Programmed-I/O Register Cycle Sequencer

This block runs a single 16-bit programmed-I/O access to a register of a parallel disk interface, on the host side. A request carries a register selector, a direction and, for writes, a data word. The block drives the two active-low bank selects, the three register address lines, the active-low read and write strobes and the outgoing data lanes, and it captures the incoming data lanes for reads. Each access has three phases: an address setup phase, a strobe phase and a recovery phase. Their lengths in clock ticks come from a five-entry speed table, and the entry is picked by a mode input.

In the two fastest modes the device can hold off the end of the strobe by pulling its ready line low. A guard counter limits how long this wait may last. When the limit is reached, the cycle is forced to end and an error flag is reported alongside completion. Completion is a one-tick pulse that follows the last recovery tick. For reads it returns the captured word.

Top module: `pio_cycle_engine`

## Requirements
- R1: While reset is held and afterwards while idle, both bank selects and both strobes are high, the data output enable is low, done is low and req_ready is high.
- R2: A request is taken only when req_ready is high. A req_valid raised during a cycle starts nothing and does not change the address lines of the cycle in progress.
- R3: req_reg[3]=1 drives cs1_n low and req_reg[3]=0 drives cs0_n low. req_reg[2:0] appears on da. Selector and address are captured at acceptance and held for the whole cycle. The strobe first goes low after 7/5/3/3/3 setup ticks for modes 0..4.
- R4: The strobe phase lasts 17/13/10/8/7 ticks for modes 0..4 when ready does not hold it. Only rd_n goes low on reads and only wr_n goes low on writes.
- R5: With no stretching, a bank select stays low for 60/39/24/18/12 ticks for modes 0..4.
- R6: On writes, dq_oe is high and dq_out carries the captured write word on every tick in which wr_n is low.
- R7: Read data is taken from dq_in on the last tick of the strobe. done is high for exactly one tick, directly after the last tick of the cycle. rdata holds the read word while done is high.
- R8: In modes 3 and 4, when iordy is low at the end of the nominal strobe, the strobe stays low one tick for each tick that iordy stays low. The cycle grows by the same amount.
- R9: In modes 0, 1 and 2, iordy has no effect on strobe width or cycle length.
- R10: If, in modes 3 and 4, iordy holds the strobe for 1250 ticks beyond the nominal width, the strobe ends anyway, the cycle completes normally and timeout_err is high alongside done. Otherwise timeout_err is low with done.
- R11: mode_sel is sampled at acceptance, so changing it during a cycle does not alter that cycle's timing.
- R12: mode_sel codes 5, 6 and 7 produce mode 0 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Speed table selector, sampled at acceptance |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_reg | input | 4 | Bit 3 selects bank, bits 2:0 register address |
| req_wdata | input | 16 | Write word |
| req_ready | output | 1 | High when idle and able to accept |
| done | output | 1 | One-tick completion pulse |
| rdata | output | 16 | Captured read word |
| timeout_err | output | 1 | Ready wait limit hit in this cycle |
| cs0_n | output | 1 | Bank 0 select, active low |
| cs1_n | output | 1 | Bank 1 select, active low |
| da | output | 3 | Register address lines |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dq_out | output | 16 | Outgoing data lanes |
| dq_oe | output | 1 | Output enable for dq_out |
| dq_in | input | 16 | Incoming data lanes |
| iordy | input | 1 | Device ready, low to stretch the strobe |

## Verification
The hardest case to reach is a stretched strobe that must end on an exact tick. This covers both a release of the ready line a known number of ticks after the nominal end and the forced end when the 1250-tick wait limit runs out. The bench counts strobe-low ticks at falling clock edges and raises iordy the moment that count reaches the nominal width plus the chosen extra. For the limit case it simply never raises iordy. The device model returns the read word only while rd_n is low, so data captured too late shows up as a wrong value.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int MODE_W    = 3;
    localparam int REG_W     = 4;
    localparam int CNT_W     = 8;
    localparam int NUM_MODES = 5;
    localparam int FAST_MIN  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV,
        ST_DONE
    } pio_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
        logic             honor_rdy;
    } pio_timing_t;

    typedef struct packed {
        logic             write;
        logic [REG_W-1:0] sel;
    } pio_op_t;

    function automatic pio_timing_t make_timing(input int s, input int a, input int c,
                                                input logic fast);
        pio_timing_t t;
        t.setup     = CNT_W'(s);
        t.active    = CNT_W'(a);
        t.recov     = CNT_W'(c - s - a);
        t.honor_rdy = fast;
        return t;
    endfunction

    function automatic pio_timing_t timing_for_mode(input logic [MODE_W-1:0] m);
        pio_timing_t t;
        case (m)
            3'd1:    t = make_timing(5, 13, 39, 1'b0);
            3'd2:    t = make_timing(3, 10, 24, 1'b0);
            3'd3:    t = make_timing(3, 8, 18, 1'b1);
            3'd4:    t = make_timing(3, 7, 12, 1'b1);
            default: t = make_timing(7, 17, 60, 1'b0);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pio_ready_guard.sv
module pio_ready_guard #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic stretch,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            wcnt <= '0;
        else if (stretch && !expired)
            wcnt <= wcnt + 1'b1;
    end

    assign expired = (wcnt == W'(LIMIT));
endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
    import pio_timing_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  pio_state_e        state,
    input  pio_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);
    logic in_cycle;
    logic strobing;
    logic driving;

    always_comb begin
        in_cycle = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_RECOV);
        strobing = (state == ST_STROBE);
        driving  = op.write && ((state == ST_STROBE) || (state == ST_RECOV));
        cs1_n    = !(in_cycle && op.sel[REG_W-1]);
        cs0_n    = !(in_cycle && !op.sel[REG_W-1]);
        da       = in_cycle ? op.sel[2:0] : 3'b000;
        rd_n     = !(strobing && !op.write);
        wr_n     = !(strobing && op.write);
        dq_oe    = driving;
        dq_out   = driving ? wdata : '0;
    end
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
    import pio_timing_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int TIMEOUT_TICKS = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout_err,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              iordy
);
    pio_state_e        state;
    pio_op_t           op_q;
    logic [DATA_W-1:0] wdata_q;
    pio_timing_t       tm_q;
    pio_timing_t       tm_new;

    logic             phase_zero;
    logic             wait_expired;
    logic             hold_strobe;
    logic             strobe_end;
    logic             stretch;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;

    always_comb begin
        tm_new      = timing_for_mode(mode_sel);
        accept      = (state == ST_IDLE) && req_valid;
        hold_strobe = tm_q.honor_rdy && !iordy;
        stretch     = (state == ST_STROBE) && phase_zero && hold_strobe;
        strobe_end  = (state == ST_STROBE) && phase_zero && (!hold_strobe || wait_expired);
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (state)
            ST_IDLE: if (accept) begin
                tmr_load = 1'b1;
                tmr_val  = tm_new.setup - 1'b1;
            end
            ST_SETUP: if (phase_zero) begin
                tmr_load = 1'b1;
                tmr_val  = tm_q.active - 1'b1;
            end
            ST_STROBE: if (strobe_end) begin
                tmr_load = 1'b1;
                tmr_val  = tm_q.recov - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            op_q        <= '0;
            wdata_q     <= '0;
            tm_q        <= '0;
            rdata       <= '0;
            timeout_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    op_q.write  <= req_write;
                    op_q.sel    <= req_reg;
                    wdata_q     <= req_wdata;
                    tm_q        <= tm_new;
                    timeout_err <= 1'b0;
                    state       <= ST_SETUP;
                end
                ST_SETUP: if (phase_zero) state <= ST_STROBE;
                ST_STROBE: if (strobe_end) begin
                    if (!op_q.write) rdata <= dq_in;
                    timeout_err <= hold_strobe;
                    state       <= ST_RECOV;
                end
                ST_RECOV: if (phase_zero) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    pio_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (phase_zero)
    );

    pio_ready_guard #(.LIMIT(TIMEOUT_TICKS)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .clear   (state != ST_STROBE),
        .stretch (stretch),
        .expired (wait_expired)
    );

    pio_bus_drive #(.DATA_W(DATA_W)) u_drive (
        .state  (state),
        .op     (op_q),
        .wdata  (wdata_q),
        .cs0_n  (cs0_n),
        .cs1_n  (cs1_n),
        .da     (da),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .dq_oe  (dq_oe),
        .dq_out (dq_out)
    );

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
endmodule

// File: rtl/pio_cycle_engine_chk.sv
module pio_cycle_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       cs0_n,
    input logic       cs1_n,
    input logic [2:0] da,
    input logic       rd_n,
    input logic       wr_n,
    input logic       dq_oe
);
    logic sel_on;
    assign sel_on = !cs0_n || !cs1_n;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cs0_n && cs1_n && rd_n && wr_n && !dq_oe && !done));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> !req_ready);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_on && $past(sel_on)) |-> ($stable(da) && $stable(cs0_n) && $stable(cs1_n)));

    assert_setup_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_on) |-> (rd_n && wr_n));

    assert_one_bank_R3: assert property (@(posedge clk) disable iff (rst)
        !(!cs0_n && !cs1_n));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (sel_on && (rd_n || wr_n)));

    assert_drive_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (sel_on && rd_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
endmodule

bind pio_cycle_engine pio_cycle_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .cs0_n     (cs0_n),
    .cs1_n     (cs1_n),
    .da        (da),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .dq_oe     (dq_oe)
);

// File: tb/pio_cycle_engine_test.sv
module pio_cycle_engine_test;
    localparam int TIMEOUT = 1250;
    localparam int NVEC    = 10;

    // {mode[32:30], write[29], reg[28:25], data[24:9], iordy_low[8], extra[7:0]}
    localparam logic [32:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 4'h7, 16'h1234, 1'b0, 8'd0},
        {3'd0, 1'b1, 4'h0, 16'hA5C3, 1'b0, 8'd0},
        {3'd1, 1'b0, 4'hE, 16'h0F0F, 1'b0, 8'd0},
        {3'd2, 1'b1, 4'h2, 16'hFFFF, 1'b0, 8'd0},
        {3'd3, 1'b0, 4'h0, 16'h8001, 1'b0, 8'd0},
        {3'd4, 1'b1, 4'h9, 16'h5555, 1'b0, 8'd0},
        {3'd3, 1'b0, 4'h5, 16'h3C3C, 1'b1, 8'd4},
        {3'd4, 1'b1, 4'h1, 16'h7E7E, 1'b1, 8'd9},
        {3'd1, 1'b0, 4'h3, 16'h2222, 1'b1, 8'd0},
        {3'd6, 1'b1, 4'h4, 16'h1357, 1'b0, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_sel = 3'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_reg = 4'h0;
    logic [15:0] req_wdata = 16'h0;
    logic        req_ready, done, timeout_err;
    logic [15:0] rdata, dq_out, dq_in;
    logic        cs0_n, cs1_n, rd_n, wr_n, dq_oe;
    logic [2:0]  da;
    logic        iordy = 1'b1;
    logic [15:0] dev_word = 16'h0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    assign dq_in = (!rd_n) ? dev_word : 16'hDEAD;

    pio_cycle_engine uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rdata(rdata), .timeout_err(timeout_err),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da), .rd_n(rd_n), .wr_n(wr_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .iordy(iordy)
    );

    function automatic int e_setup(input int m);
        case (m) 1: return 5; 2: return 3; 3: return 3; 4: return 3; default: return 7; endcase
    endfunction
    function automatic int e_act(input int m);
        case (m) 1: return 13; 2: return 10; 3: return 8; 4: return 7; default: return 17; endcase
    endfunction
    function automatic int e_cyc(input int m);
        case (m) 1: return 39; 2: return 24; 3: return 18; 4: return 12; default: return 60; endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_access(input logic [2:0] m, input bit wr, input logic [3:0] rs,
                             input logic [15:0] d, input bit low, input int k,
                             input bit chg, input bit busy);
        int cyc = 0, setup = 0, width = 0, bad_addr = 0, bad_strobe = 0, bad_data = 0;
        int em, exp_w, later = 0;
        bit fast, timed;
        string wreq;
        em    = (m > 4) ? 0 : int'(m);
        fast  = (em >= 3);
        timed = fast && low && (k < 0);
        exp_w = e_act(em) + ((fast && low) ? ((k < 0) ? TIMEOUT : k) : 0);
        wreq  = (fast && low) ? (timed ? "R10" : "R8") : (low ? "R9" : "R4");
        @(negedge clk);
        mode_sel = m; req_write = wr; req_reg = rs; req_wdata = wr ? d : 16'h0;
        dev_word = d; iordy = !low; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_reg = ~rs; req_wdata = ~d;
        for (int t = 0; t < 4000 && !done; t++) begin
            if (!cs0_n || !cs1_n) begin
                cyc++;
                if ((cs1_n != !rs[3]) || (cs0_n != rs[3]) || (da != rs[2:0])) bad_addr++;
                if (rd_n && wr_n && width == 0) setup++;
            end
            if (!rd_n || !wr_n) begin
                width++;
                if ((wr && !rd_n) || (!wr && !wr_n)) bad_strobe++;
                if (wr && (!dq_oe || dq_out != d)) bad_data++;
            end
            if (chg && cyc == 2) mode_sel = (m == 3'd4) ? 3'd0 : 3'd4;
            if (busy && cyc == 2) begin req_valid = 1'b1; req_reg = 4'hF; end
            if (busy && cyc == 3) req_valid = 1'b0;
            if (fast && low && k >= 0 && width == e_act(em) + k) iordy = 1'b1;
            @(negedge clk);
        end
        check(done == 1'b1, "R7 done seen", int'(done), 1);
        check(cyc == e_cyc(em) + exp_w - e_act(em), chg ? "R11 cycle length" : (m > 4 ? "R12 cycle length" : "R5 cycle length"),
              cyc, e_cyc(em) + exp_w - e_act(em));
        check(setup == e_setup(em), "R3 setup ticks", setup, e_setup(em));
        check(width == exp_w, wreq, width, exp_w);
        check(bad_addr == 0, busy ? "R2 address kept" : "R3 address", bad_addr, 0);
        check(bad_strobe == 0, "R4 strobe direction", bad_strobe, 0);
        if (wr) check(bad_data == 0, "R6 write data", bad_data, 0);
        else    check(rdata == d, "R7 read data", int'(rdata), int'(d));
        check(timeout_err == timed, timed ? "R10 timeout flag" : "R8 no timeout flag", int'(timeout_err), int'(timed));
        @(negedge clk);
        check(!done && req_ready, "R7 single done", int'(done), 0);
        if (busy) begin
            for (int j = 0; j < 4; j++) begin
                if (!cs0_n || !cs1_n) later++;
                @(negedge clk);
            end
            check(later == 0, "R2 no second cycle", later, 0);
        end
        iordy = 1'b1;
        mode_sel = 3'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs0_n && cs1_n && rd_n && wr_n && !dq_oe && !done && req_ready, "R1 reset state",
              int'({cs0_n, cs1_n, rd_n, wr_n, dq_oe, done, req_ready}), 7'b1111001);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && cs0_n && cs1_n, "R1 idle after reset", int'(req_ready), 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] v;
            v = VEC[i];
            do_access(v[32:30], v[29], v[28:25], v[24:9], v[8], int'(v[7:0]), 1'b0, 1'b0);
        end

        do_access(3'd0, 1'b0, 4'hB, 16'h6A6A, 1'b0, 0, 1'b1, 1'b0);   // R11
        do_access(3'd4, 1'b1, 4'h6, 16'h0C0C, 1'b0, 0, 1'b1, 1'b0);   // R11
        do_access(3'd2, 1'b1, 4'hA, 16'h4321, 1'b0, 0, 1'b0, 1'b1);   // R2
        do_access(3'd4, 1'b0, 4'hD, 16'h9ABC, 1'b1, -1, 1'b0, 1'b0);  // R10
        do_access(3'd3, 1'b0, 4'h2, 16'hFACE, 1'b0, 0, 1'b0, 1'b0);   // R10 flag clears

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule